// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Register Unit

This unit keeps the two threshold offsets that a FIFO's programmable flag logic compares its fill level against. One offset sets how close to empty the almost-empty flag switches, and the other sets how close to full the almost-full flag switches. The unit does no comparison itself. It only presents both offsets as steady outputs.

At master reset, the level of the load-qualify pin picks one of two setups. A low level gives both offsets a small default and allows loads from the parallel data bus. A high level gives both offsets a large default and allows loads one bit at a time from a serial input. Once reset is released, the load method cannot change. Either way, software can read the offsets back in parallel through the read port. While the load-qualify pin is high, write and read strobes act on this unit and are kept away from the FIFO pointers. A partial reset returns the load and read sequences to their start but keeps the offsets and the load method.

Top module: `flag_ofs_unit`

## Requirements
- R1: Master reset (rst_ni low across at least one wclk_i edge) with ld_i low loads DEF_LO into both offsets and selects the parallel load method. q_o resets to 0.
- R2: Master reset with ld_i high loads DEF_HI into both offsets and selects the serial load method.
- R3: In parallel method, each wclk_i edge with wen_i and ld_i high copies d_i[OFS_W-1:0] into one offset. The first edge after reset writes almost-empty, the next writes almost-full, and the sequence then wraps to almost-empty.
- R4: In serial method, each wclk_i edge with sen_i and ld_i high shifts si_i in. After 2*OFS_W shifts, the first bit sits in almost-empty bit 0 and bit number OFS_W of the stream sits in almost-full bit 0 (LSB first, almost-empty before almost-full).
- R5: The load method is fixed at reset. wen_i with ld_i does nothing in serial method, and sen_i with ld_i does nothing in parallel method.
- R6: Each rclk_i edge with ren_i and ld_i high drives q_o with the next offset, zero-extended to DATA_W. The order is almost-empty first, then almost-full, then wrapping. This works in both methods. q_o holds its value on all other edges.
- R7: While part_rst_ni is low at a clock edge, no load or read takes place and that domain's sequence returns to almost-empty. The offsets and the load method stay unchanged.
- R8: ptr_wen_o equals wen_i with ld_i low, and ptr_ren_o equals ren_i with ld_i low.
- R9: wen_i, sen_i or ren_i without ld_i leaves both offsets and q_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Master reset, active low |
| part_rst_ni | input | 1 | Partial reset, active low, synchronous in each domain |
| ld_i | input | 1 | Offset access qualify; at master reset selects default and method |
| wen_i | input | 1 | Write strobe |
| sen_i | input | 1 | Serial shift strobe |
| si_i | input | 1 | Serial data in |
| d_i | input | DATA_W | Parallel data in |
| ren_i | input | 1 | Read strobe |
| q_o | output | DATA_W | Offset readback |
| ae_ofs_o | output | OFS_W | Almost-empty offset |
| af_ofs_o | output | OFS_W | Almost-full offset |
| ptr_wen_o | output | 1 | Write strobe passed to FIFO pointers |
| ptr_ren_o | output | 1 | Read strobe passed to FIFO pointers |

## Verification
The bench uses the default parameters: OFS_W of 10, DATA_W of 12, and defaults of 127 and 1023. With a 10-bit offset, the large default fills every bit, which is the highest value an offset can hold. A serial load is then a 20-edge stream that crosses the boundary between the two registers. A 12-bit bus lets the bench drive nonzero upper data bits, so it can check that writes drop them and that readback zero-extends. The two clocks run at the same rate with a phase offset, so the write and read sequences are exercised independently.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} ofs_sel_e;

  function automatic ofs_sel_e next_sel(ofs_sel_e s);
    return (s == SEL_AE) ? SEL_AF : SEL_AE;
  endfunction
endpackage

// File: rtl/ofs_wr_ctl.sv
module ofs_wr_ctl
  import ofs_pkg::*;
#(
  parameter int unsigned OFS_W  = 10,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEF_LO = 127,
  parameter int unsigned DEF_HI = 1023
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              part_rst_ni,
  input  logic              ld_i,
  input  logic              wen_i,
  input  logic              sen_i,
  input  logic              si_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [OFS_W-1:0]  ae_ofs_o,
  output logic [OFS_W-1:0]  af_ofs_o
);
  localparam int unsigned     SH_W = 2 * OFS_W;
  localparam logic [OFS_W-1:0] LO_V = OFS_W'(DEF_LO);
  localparam logic [OFS_W-1:0] HI_V = OFS_W'(DEF_HI);

  logic            ser_mode_q;
  ofs_sel_e        wr_sel_q;
  logic [SH_W-1:0] ofs_q;   // {af, ae}
  logic            par_wr, ser_sh;

  assign par_wr = wen_i & ld_i & ~ser_mode_q & part_rst_ni;
  assign ser_sh = sen_i & ld_i &  ser_mode_q & part_rst_ni;

  // defaults and method sampled from ld_i while master reset is held
  always_ff @(posedge wclk_i) begin
    if (!rst_ni) begin
      ser_mode_q <= ld_i;
      ofs_q      <= ld_i ? {HI_V, HI_V} : {LO_V, LO_V};
    end else if (ser_sh) begin
      ofs_q <= {si_i, ofs_q[SH_W-1:1]};
    end else if (par_wr) begin
      if (wr_sel_q == SEL_AE) ofs_q[OFS_W-1:0]    <= d_i[OFS_W-1:0];
      else                    ofs_q[SH_W-1:OFS_W] <= d_i[OFS_W-1:0];
    end
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni)           wr_sel_q <= SEL_AE;
    else if (!part_rst_ni) wr_sel_q <= SEL_AE;
    else if (par_wr)       wr_sel_q <= next_sel(wr_sel_q);
  end

  assign ae_ofs_o = ofs_q[OFS_W-1:0];
  assign af_ofs_o = ofs_q[SH_W-1:OFS_W];

  AST_PAR_AE_LOAD: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    par_wr && wr_sel_q == SEL_AE |=> ae_ofs_o == $past(d_i[OFS_W-1:0])); // R3
  AST_PAR_AF_LOAD: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    par_wr && wr_sel_q == SEL_AF |=> af_ofs_o == $past(d_i[OFS_W-1:0])); // R3
  AST_SER_ENTRY: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ser_sh |=> af_ofs_o[OFS_W-1] == $past(si_i)); // R4
  AST_OFS_HOLD: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !ser_sh && !par_wr |=> $stable(ae_ofs_o) && $stable(af_ofs_o)); // R9
  AST_MODE_FIXED: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(ser_mode_q)); // R5
  AST_WR_PRS: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !part_rst_ni |=> wr_sel_q == SEL_AE); // R7
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
  import ofs_pkg::*;
#(
  parameter int unsigned OFS_W  = 10,
  parameter int unsigned DATA_W = 12
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              part_rst_ni,
  input  logic              ld_i,
  input  logic              ren_i,
  input  logic [OFS_W-1:0]  ae_ofs_i,
  input  logic [OFS_W-1:0]  af_ofs_i,
  output logic [DATA_W-1:0] q_o
);
  ofs_sel_e rd_sel_q;
  logic     rd_en;

  assign rd_en = ren_i & ld_i & part_rst_ni;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sel_q <= SEL_AE;
      q_o      <= '0;
    end else if (!part_rst_ni) begin
      rd_sel_q <= SEL_AE;
    end else if (rd_en) begin
      q_o      <= DATA_W'((rd_sel_q == SEL_AE) ? ae_ofs_i : af_ofs_i);
      rd_sel_q <= next_sel(rd_sel_q);
    end
  end

  AST_RD_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(q_o)); // R6
  AST_RD_AE: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_en && rd_sel_q == SEL_AE |=> q_o == DATA_W'($past(ae_ofs_i))); // R6
  AST_RD_PRS: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !part_rst_ni |=> rd_sel_q == SEL_AE); // R7
endmodule

// File: rtl/flag_ofs_unit.sv
module flag_ofs_unit
  import ofs_pkg::*;
#(
  parameter int unsigned OFS_W  = 10,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEF_LO = 127,
  parameter int unsigned DEF_HI = 1023
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              part_rst_ni,
  input  logic              ld_i,
  input  logic              wen_i,
  input  logic              sen_i,
  input  logic              si_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic              ren_i,
  output logic [DATA_W-1:0] q_o,
  output logic [OFS_W-1:0]  ae_ofs_o,
  output logic [OFS_W-1:0]  af_ofs_o,
  output logic              ptr_wen_o,
  output logic              ptr_ren_o
);
  ofs_wr_ctl #(
    .OFS_W(OFS_W), .DATA_W(DATA_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
  ) u_wr (
    .wclk_i(wclk_i), .rst_ni(rst_ni), .part_rst_ni(part_rst_ni),
    .ld_i(ld_i), .wen_i(wen_i), .sen_i(sen_i), .si_i(si_i), .d_i(d_i),
    .ae_ofs_o(ae_ofs_o), .af_ofs_o(af_ofs_o)
  );

  ofs_rd_port #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rd (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .part_rst_ni(part_rst_ni),
    .ld_i(ld_i), .ren_i(ren_i), .ae_ofs_i(ae_ofs_o), .af_ofs_i(af_ofs_o),
    .q_o(q_o)
  );

  // offset access steals the strobes from the FIFO pointers
  assign ptr_wen_o = wen_i & ~ld_i;
  assign ptr_ren_o = ren_i & ~ld_i;
endmodule

// File: tb/tb_flag_ofs_unit.sv
`timescale 1ns/1ps
module tb_flag_ofs_unit;
  localparam int OFS_W = 10, DATA_W = 12, DEF_LO = 127, DEF_HI = 1023;

  logic wclk_i = 0, rclk_i = 0;
  logic rst_ni = 1, part_rst_ni = 1, ld_i = 0, wen_i = 0, sen_i = 0, si_i = 0, ren_i = 0;
  logic [DATA_W-1:0] d_i = '0;
  logic [DATA_W-1:0] q_o;
  logic [OFS_W-1:0]  ae_ofs_o, af_ofs_o;
  logic ptr_wen_o, ptr_ren_o;

  int checks = 0, errors = 0;
  logic [OFS_W-1:0] exp_ae, exp_af;

  always #2.5 wclk_i = ~wclk_i;
  initial begin #1.2; forever #2.5 rclk_i = ~rclk_i; end

  flag_ofs_unit #(.OFS_W(OFS_W), .DATA_W(DATA_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) dut (
    .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .part_rst_ni(part_rst_ni),
    .ld_i(ld_i), .wen_i(wen_i), .sen_i(sen_i), .si_i(si_i), .d_i(d_i), .ren_i(ren_i),
    .q_o(q_o), .ae_ofs_o(ae_ofs_o), .af_ofs_o(af_ofs_o),
    .ptr_wen_o(ptr_wen_o), .ptr_ren_o(ptr_ren_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ofs(string req);
    chk(req, 32'(ae_ofs_o), 32'(exp_ae));
    chk(req, 32'(af_ofs_o), 32'(exp_af));
  endtask

  task automatic mrs(logic lvl);
    @(negedge wclk_i);
    rst_ni = 0; ld_i = lvl;
    repeat (3) @(posedge wclk_i);
    @(negedge wclk_i);
    rst_ni = 1; ld_i = 0;
  endtask

  task automatic wr_par(logic [DATA_W-1:0] d);
    @(negedge wclk_i); wen_i = 1; ld_i = 1; d_i = d;
    @(negedge wclk_i); wen_i = 0; ld_i = 0;
  endtask

  task automatic sh_bit(logic b);
    @(negedge wclk_i); sen_i = 1; ld_i = 1; si_i = b;
    @(negedge wclk_i); sen_i = 0; ld_i = 0;
  endtask

  task automatic rd_par();
    @(negedge rclk_i); ren_i = 1; ld_i = 1;
    @(negedge rclk_i); ren_i = 0; ld_i = 0;
  endtask

  task automatic prs();
    @(negedge wclk_i); part_rst_ni = 0;
    @(posedge wclk_i); @(posedge rclk_i);
    @(negedge wclk_i); part_rst_ni = 1;
  endtask

  task automatic t_reset_par();
    mrs(1'b0);
    exp_ae = OFS_W'(DEF_LO); exp_af = OFS_W'(DEF_LO);
    chk_ofs("R1 default low");
    chk("R1 q reset", 32'(q_o), 0);
  endtask

  task automatic t_gating();
    @(negedge wclk_i); wen_i = 1; ren_i = 1; ld_i = 0; #0.5;
    chk("R8 wen pass", 32'(ptr_wen_o), 1);
    chk("R8 ren pass", 32'(ptr_ren_o), 1);
    ld_i = 1; #0.5;
    chk("R8 wen block", 32'(ptr_wen_o), 0);
    chk("R8 ren block", 32'(ptr_ren_o), 0);
    ld_i = 0; ren_i = 0;
    sen_i = 1; d_i = 12'h0AB;
    repeat (2) @(negedge wclk_i);
    wen_i = 0; sen_i = 0;
    chk_ofs("R9 strobes without ld");
    chk("R9 q unchanged", 32'(q_o), 0);
  endtask

  task automatic t_par_load();
    wr_par(12'hF05); exp_ae = 10'h305;
    chk_ofs("R3 load ae upper bits dropped");
    wr_par(12'd300); exp_af = 10'd300;
    chk_ofs("R3 load af");
    wr_par(12'd17); exp_ae = 10'd17;
    chk_ofs("R3 wrap to ae");
    // serial shift in parallel method must not move anything
    sh_bit(1'b1); sh_bit(1'b0);
    chk_ofs("R5 shift ignored in parallel method");
  endtask

  task automatic t_readback(string tag);
    rd_par(); chk({tag, " R6 read ae"}, 32'(q_o), 32'(exp_ae));
    rd_par(); chk({tag, " R6 read af"}, 32'(q_o), 32'(exp_af));
    @(negedge rclk_i); ren_i = 1;
    @(negedge rclk_i); ren_i = 0;
    chk({tag, " R9 ren without ld holds q"}, 32'(q_o), 32'(exp_af));
    rd_par(); chk({tag, " R6 read wraps to ae"}, 32'(q_o), 32'(exp_ae));
  endtask

  task automatic t_partial();
    // write index now at af (three writes done), read index at af
    prs();
    chk_ofs("R7 offsets kept");
    wr_par(12'd44); exp_ae = 10'd44;
    chk_ofs("R7 write index back at ae");
    rd_par();
    chk("R7 read index back at ae", 32'(q_o), 32'(exp_ae));
    sh_bit(1'b1);
    chk_ofs("R7 method kept parallel");
  endtask

  task automatic t_serial();
    logic [2*OFS_W-1:0] stream;
    mrs(1'b1);
    exp_ae = OFS_W'(DEF_HI); exp_af = OFS_W'(DEF_HI);
    chk_ofs("R2 default high");
    wr_par(12'd5);
    chk_ofs("R5 parallel write ignored in serial method");
    stream = {10'h2AA, 10'h155};
    for (int i = 0; i < 2 * OFS_W; i++) sh_bit(stream[i]);
    exp_ae = 10'h155; exp_af = 10'h2AA;
    chk_ofs("R4 serial stream");
    t_readback("serial");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_par();
    t_gating();
    t_par_load();
    // sequence reads from ae: three reads leave index at af
    t_readback("parallel");
    t_partial();
    t_serial();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule